// File: doc/BRIEF.md
# Pipelined Burst Transfer Sequencer

This block is the issuing side of a bus master. It takes one burst request at a time and turns it into a pipelined stream of transfers. A request carries a start address, a transfer size, a beat count, a direction and a flag that selects a wrapping or an incrementing address pattern. Each beat is announced in an address phase that shows a two-bit transfer-type code, the address, the size and the direction. The data for that beat moves one cycle later, so the address phase of the next beat overlaps the data phase of the current one.

A single `bus_ready` input stalls both phases together. When the sequencer has no work it drives the idle code. It never drives the reserved busy code. Write data is pulled from a local source one beat at a time. A pulled word appears on the bus in the following data phase. Read data is passed back with a strobe that marks the cycle in which a read data phase completes.

A new request is taken while the last beat of the previous burst is in its address phase. Bursts can therefore follow one another with no idle cycle between them. The reset input is asynchronous and active low. Its release is synchronised inside the block, and no request is taken until that release has passed through.

Top module: `burst_seq`

## Requirements
- R1: While reset is in effect, `bus_trans` is 00, and `req_ready`, `src_pop` and `rd_valid` are low. Outside reset, `bus_trans` is 00 in every cycle in which no accepted beat is pending.
- R2: `bus_trans` never takes the value 01.
- R3: The first beat of every burst is driven with `bus_trans` = 10 at `req_addr`, in the cycle after the request is accepted. A request with `req_len` = 0 is a burst of one beat and has only this beat.
- R4: Each later beat of a burst is driven with `bus_trans` = 11. For an incrementing burst its address is the previous beat's address plus the beat size in bytes (size code 0, 1, 2 = 1, 2, 4 bytes).
- R5: When `req_wrap` = 1 and `req_len` is 3, 7 or 15, the address wraps within an aligned window of (beats × size bytes). When `req_wrap` = 1 with any other length, the burst is incrementing.
- R6: `bus_size` and `bus_write` stay the same on every beat of a burst.
- R7: While `bus_ready` is low, the address-phase outputs, `bus_wdata` and the internal state hold their values, and no request is accepted.
- R8: `src_pop` is high exactly in the cycles in which a write beat's address phase completes (`bus_ready` high). The `src_wdata` sampled in such a cycle is driven on `bus_wdata` from the next cycle until the next completed beat.
- R9: `req_ready` is high exactly when `bus_ready` is high and either no beat is pending or the pending beat is the last one of its burst. A request accepted in that cycle starts its burst in the next cycle with no idle cycle.
- R10: `rd_valid` is high exactly when a read data phase is current and `bus_ready` is high. In that cycle `rd_data` equals `bus_rdata`.
- R11: A request with `req_len` = L produces exactly L+1 beats (`req_len` is the beat count minus one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A burst request is offered |
| req_ready | output | 1 | Request taken this cycle when `req_valid` is high |
| req_addr | input | AW | Start address, aligned to the size |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_len | input | LENW | Beat count minus one |
| req_wrap | input | 1 | 1 selects the wrapping pattern |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| bus_ready | input | 1 | Bus accepts the current phases; low stalls both |
| bus_trans | output | 2 | Transfer type: 00 idle, 10 first beat, 11 later beat |
| bus_addr | output | AW | Address of the current address phase |
| bus_size | output | 2 | Size code of the current address phase |
| bus_write | output | 1 | Direction of the current address phase |
| bus_wdata | output | DW | Write data of the current data phase |
| bus_rdata | input | DW | Read data from the bus |
| src_wdata | input | DW | Next write word from the local source |
| src_pop | output | 1 | The local source word is consumed this cycle |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | DW | Read data to the local sink |

## Verification
Directed bursts cover the main cases. A single write checks the one-beat case. Word, halfword and byte wrapping reads and writes of 4, 8 and 16 beats, all started mid-window, tell wrapping apart from plain incrementing. A wrap request with a length of six has to behave as incrementing. A 16-beat incrementing burst and a chain of requests with no gap show the hand-over between bursts with no idle cycle. The same bursts are then run again under random `bus_ready` stalls, followed by a long random mix of sizes, lengths, directions, gaps and stall rates. The stalled runs separate the held-phase behaviour and the one-cycle data lag from the unstalled timing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam int unsigned SIZE_W = 2;

  // Number of beat counts that allow a wrapping pattern (4, 8, 16).
  localparam int unsigned WRAP_KINDS = 3;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned LENW = 4
) (
  input  logic [AW-1:0]     cur_addr,
  input  logic [SIZE_W-1:0] cur_size,
  input  logic              cur_wrap,
  input  logic [AW-1:0]     cur_mask,
  input  logic [LENW-1:0]   ld_len,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              ld_wrap,
  output logic [AW-1:0]     nxt_addr,
  output logic [AW-1:0]     ld_mask,
  output logic              ld_wrap_ok
);

  logic [AW-1:0]         step;
  logic [AW-1:0]         sum;
  logic [WRAP_KINDS-1:0] len_hit;

  // One comparator per beat count that permits wrapping.
  generate
    for (genvar g = 0; g < WRAP_KINDS; g++) begin : g_wlen
      localparam int unsigned BEATS = 4 << g;
      if (BEATS <= (1 << LENW)) begin : g_fit
        assign len_hit[g] = (ld_len == LENW'(BEATS - 1));
      end else begin : g_nofit
        assign len_hit[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    step     = AW'(1) << cur_size;
    sum      = cur_addr + step;
    nxt_addr = cur_wrap ? ((cur_addr & ~cur_mask) | (sum & cur_mask)) : sum;
  end

  always_comb begin
    ld_mask    = ((AW'(ld_len) + AW'(1)) << ld_size) - AW'(1);
    ld_wrap_ok = ld_wrap && (|len_hit);
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned LENW = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              adv,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LENW-1:0]   req_len,
  input  logic              req_write,
  input  logic              ld_wrap_ok,
  input  logic [AW-1:0]     ld_mask,
  input  logic [AW-1:0]     nxt_addr,
  output logic              req_ready,
  output trans_e            beat_trans,
  output logic              beat_live,
  output logic [AW-1:0]     beat_addr,
  output logic [SIZE_W-1:0] beat_size,
  output logic              beat_write,
  output logic              beat_wrap,
  output logic [AW-1:0]     beat_mask
);

  logic              live_q, live_d;
  logic              first_q, first_d;
  logic              write_q, write_d;
  logic              wrap_q, wrap_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [AW-1:0]     mask_q, mask_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [LENW-1:0]   left_q, left_d;
  logic              last_beat;
  logic              open_slot;

  assign last_beat = (left_q == '0);
  assign open_slot = srst_n && (!live_q || last_beat);
  assign req_ready = adv && open_slot;

  // Next state, applied only in cycles where the bus advances.
  always_comb begin
    live_d  = live_q;
    first_d = first_q;
    write_d = write_q;
    wrap_d  = wrap_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    size_d  = size_q;
    left_d  = left_q;
    if (live_q && !last_beat) begin
      addr_d  = nxt_addr;
      left_d  = left_q - LENW'(1);
      first_d = 1'b0;
    end else if (req_valid) begin
      live_d  = 1'b1;
      first_d = 1'b1;
      addr_d  = req_addr;
      size_d  = req_size;
      write_d = req_write;
      wrap_d  = ld_wrap_ok;
      mask_d  = ld_mask;
      left_d  = req_len;
    end else begin
      live_d  = 1'b0;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      live_q  <= 1'b0;
      first_q <= 1'b0;
      write_q <= 1'b0;
      wrap_q  <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      size_q  <= '0;
      left_q  <= '0;
    end else if (adv) begin
      live_q  <= live_d;
      first_q <= first_d;
      write_q <= write_d;
      wrap_q  <= wrap_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      size_q  <= size_d;
      left_q  <= left_d;
    end
  end

  always_comb begin
    if (!live_q)      beat_trans = TR_IDLE;
    else if (first_q) beat_trans = TR_NSEQ;
    else              beat_trans = TR_SEQ;
  end

  assign beat_live  = live_q;
  assign beat_addr  = addr_q;
  assign beat_size  = size_q;
  assign beat_write = write_q;
  assign beat_wrap  = wrap_q;
  assign beat_mask  = mask_q;

endmodule

// File: rtl/burst_data_phase.sv
module burst_data_phase #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          adv,
  input  logic          beat_live,
  input  logic          beat_write,
  input  logic [DW-1:0] src_wdata,
  output logic          src_pop,
  output logic [DW-1:0] dp_wdata,
  output logic          rd_valid
);

  logic          dp_live_q, dp_live_d;
  logic          dp_wr_q, dp_wr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          cap;

  assign cap = adv && beat_live && beat_write;

  always_comb begin
    dp_live_d = beat_live;
    dp_wr_d   = beat_live && beat_write;
    wdata_d   = src_wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dp_live_q <= 1'b0;
      dp_wr_q   <= 1'b0;
    end else if (adv) begin
      dp_live_q <= dp_live_d;
      dp_wr_q   <= dp_wr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wdata_q <= '0;
    end else if (cap) begin
      wdata_q <= wdata_d;
    end
  end

  assign src_pop  = cap;
  assign dp_wdata = wdata_q;
  assign rd_valid = adv && dp_live_q && !dp_wr_q;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic [LENW-1:0] req_len,
  input  logic            req_wrap,
  input  logic            req_write,
  input  logic            bus_ready,
  output logic [1:0]      bus_trans,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_size,
  output logic            bus_write,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   src_wdata,
  output logic            src_pop,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);

  logic              srst_n;
  trans_e            beat_trans;
  logic              beat_live;
  logic [AW-1:0]     beat_addr;
  logic [SIZE_W-1:0] beat_size;
  logic              beat_write;
  logic              beat_wrap;
  logic [AW-1:0]     beat_mask;
  logic [AW-1:0]     nxt_addr;
  logic [AW-1:0]     ld_mask;
  logic              ld_wrap_ok;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  burst_addr_step #(.AW(AW), .LENW(LENW)) u_step (
    .cur_addr   (beat_addr),
    .cur_size   (beat_size),
    .cur_wrap   (beat_wrap),
    .cur_mask   (beat_mask),
    .ld_len     (req_len),
    .ld_size    (req_size),
    .ld_wrap    (req_wrap),
    .nxt_addr   (nxt_addr),
    .ld_mask    (ld_mask),
    .ld_wrap_ok (ld_wrap_ok)
  );

  burst_beat_ctrl #(.AW(AW), .LENW(LENW)) u_ctrl (
    .clk        (clk),
    .srst_n     (srst_n),
    .adv        (bus_ready),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_len    (req_len),
    .req_write  (req_write),
    .ld_wrap_ok (ld_wrap_ok),
    .ld_mask    (ld_mask),
    .nxt_addr   (nxt_addr),
    .req_ready  (req_ready),
    .beat_trans (beat_trans),
    .beat_live  (beat_live),
    .beat_addr  (beat_addr),
    .beat_size  (beat_size),
    .beat_write (beat_write),
    .beat_wrap  (beat_wrap),
    .beat_mask  (beat_mask)
  );

  burst_data_phase #(.DW(DW)) u_data (
    .clk        (clk),
    .srst_n     (srst_n),
    .adv        (bus_ready),
    .beat_live  (beat_live),
    .beat_write (beat_write),
    .src_wdata  (src_wdata),
    .src_pop    (src_pop),
    .dp_wdata   (bus_wdata),
    .rd_valid   (rd_valid)
  );

  assign bus_trans = beat_trans;
  assign bus_addr  = beat_addr;
  assign bus_size  = beat_size;
  assign bus_write = beat_write;
  assign rd_data   = bus_rdata;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    bus_trans,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          bus_write,
  input logic [DW-1:0] bus_wdata,
  input logic          src_pop,
  input logic [DW-1:0] src_wdata
);

  p_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans != 2'b01);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && bus_trans != 2'b00) |=>
      ($stable(bus_trans) && $stable(bus_addr) && $stable(bus_size) && $stable(bus_write)));

  p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> $stable(bus_wdata));

  p_ctrl_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b11) |-> (bus_size == $past(bus_size) && bus_write == $past(bus_write)));

  p_seq_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b11) |-> ($past(bus_trans) != 2'b00));

  p_first_nseq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_trans == 2'b10));

  p_wdata_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> (bus_wdata == $past(src_wdata)));

endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ready (bus_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_trans (bus_trans),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_write (bus_write),
  .bus_wdata (bus_wdata),
  .src_pop   (src_pop),
  .src_wdata (src_wdata)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  localparam int unsigned AW   = 32;
  localparam int unsigned DW   = 32;
  localparam int unsigned LENW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [AW-1:0]   req_addr;
  logic [1:0]      req_size;
  logic [LENW-1:0] req_len;
  logic            req_wrap;
  logic            req_write;
  logic            bus_ready;
  logic [1:0]      bus_trans;
  logic [AW-1:0]   bus_addr;
  logic [1:0]      bus_size;
  logic            bus_write;
  logic [DW-1:0]   bus_wdata;
  logic [DW-1:0]   bus_rdata;
  logic [DW-1:0]   src_wdata;
  logic            src_pop;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;

  always #10 clk = ~clk;

  burst_seq #(.AW(AW), .DW(DW), .LENW(LENW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_len(req_len), .req_wrap(req_wrap), .req_write(req_write),
    .bus_ready(bus_ready), .bus_trans(bus_trans), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_wdata(src_wdata), .src_pop(src_pop),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]    tr;
    logic [AW-1:0] ad;
    logic [1:0]    sz;
    logic          wr;
    logic          wp;
  } beat_t;

  beat_t exq[$];
  int n_run = 0;
  int n_fail = 0;
  int beats_exp = 0;
  int beats_seen = 0;
  int stall_pct = 0;
  bit finished = 0;

  logic          dpw_v = 1'b0;
  logic [DW-1:0] dpw_d = '0;
  logic          dpr_v = 1'b0;

  bit            pv_valid = 0;
  logic          pv_ready;
  logic [1:0]    pv_trans;
  logic [AW-1:0] pv_addr;
  logic [1:0]    pv_size;
  logic          pv_write;

  bit              p_valid = 0;
  logic [AW-1:0]   p_addr;
  logic [1:0]      p_size;
  logic [LENW-1:0] p_len;
  logic            p_wrap;
  logic            p_write;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected address of beat k, from the window rule of R4/R5.
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int sz,
                                             input int len, input bit wp, input int k);
    longint unsigned bytes, span, base, aa;
    bytes = longint'(1) << sz;
    aa    = longint'(a);
    if (!wp) return AW'(aa + longint'(k) * bytes);
    span = bytes * longint'(len + 1);
    base = aa - (aa % span);
    return AW'(base + ((aa - base + longint'(k) * bytes) % span));
  endfunction

  task automatic push_burst(input logic [AW-1:0] a, input logic [1:0] sz,
                            input logic [LENW-1:0] len, input logic wr, input logic wrap);
    beat_t b;
    bit wp;
    wp = wrap && (len == 3 || len == 7 || len == 15);
    for (int k = 0; k <= int'(len); k++) begin
      b.tr = (k == 0) ? 2'b10 : 2'b11;
      b.ad = exp_addr(a, int'(sz), int'(len), wp, k);
      b.sz = sz;
      b.wr = wr;
      b.wp = wp;
      exq.push_back(b);
    end
    beats_exp += int'(len) + 1;
  endtask

  task automatic step();
    beat_t hd;
    bit has, done, exp_rr;
    hd = '0;
    bus_ready = ($urandom_range(99) >= stall_pct);
    src_wdata = $urandom;
    bus_rdata = $urandom;
    req_valid = p_valid;
    req_addr  = p_addr;
    req_size  = p_size;
    req_len   = p_len;
    req_wrap  = p_wrap;
    req_write = p_write;
    #2;
    has = (exq.size() != 0);
    if (has) hd = exq[0];
    chk(bus_trans != 2'b01, "R2", "reserved code", 64'(bus_trans), 64'(0));
    if (!has) begin
      chk(bus_trans == 2'b00, "R1", "idle code", 64'(bus_trans), 64'(0));
    end else begin
      chk(bus_trans == hd.tr, (hd.tr == 2'b10) ? "R3" : "R4", "trans", 64'(bus_trans), 64'(hd.tr));
      chk(bus_addr == hd.ad, hd.wp ? "R5" : "R4", "addr", 64'(bus_addr), 64'(hd.ad));
      chk(bus_size == hd.sz && bus_write == hd.wr, "R6", "size/dir",
          64'({bus_size, bus_write}), 64'({hd.sz, hd.wr}));
    end
    exp_rr = bus_ready && (exq.size() <= 1);
    chk(req_ready == exp_rr, "R9", "req_ready", 64'(req_ready), 64'(exp_rr));
    if (pv_valid && !pv_ready && pv_trans != 2'b00)
      chk(bus_trans == pv_trans && bus_addr == pv_addr && bus_size == pv_size && bus_write == pv_write,
          "R7", "stall hold addr", 64'(bus_addr), 64'(pv_addr));
    chk(src_pop == (bus_ready && has && hd.wr), "R8", "src_pop", 64'(src_pop),
        64'(bus_ready && has && hd.wr));
    if (dpw_v) chk(bus_wdata == dpw_d, "R8", "wdata", 64'(bus_wdata), 64'(dpw_d));
    chk(rd_valid == (dpr_v && bus_ready), "R10", "rd_valid", 64'(rd_valid), 64'(dpr_v && bus_ready));
    if (rd_valid) chk(rd_data == bus_rdata, "R10", "rd_data", 64'(rd_data), 64'(bus_rdata));
    pv_valid = 1;
    pv_ready = bus_ready;
    pv_trans = bus_trans;
    pv_addr  = bus_addr;
    pv_size  = bus_size;
    pv_write = bus_write;
    done = bus_ready && has;
    if (bus_ready) begin
      dpw_v = done && hd.wr;
      if (done && hd.wr) dpw_d = src_wdata;
      dpr_v = done && !hd.wr;
    end
    if (done) begin
      void'(exq.pop_front());
      beats_seen++;
    end
    if (req_valid && req_ready) begin
      push_burst(p_addr, p_size, p_len, p_write, p_wrap);
      p_valid = 0;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [1:0] sz, input int len,
                      input logic wr, input logic wrap, input int gap);
    repeat (gap) step();
    p_addr  = a;
    p_size  = sz;
    p_len   = LENW'(len);
    p_wrap  = wrap;
    p_write = wr;
    p_valid = 1;
    while (p_valid) step();
  endtask

  task automatic directed_set();
    send(32'h0000_0100, 2'd0 + 2'd2, 0, 1'b1, 1'b0, 0);  // R3: single write
    send(32'h0000_0038, 2'd2, 3, 1'b0, 1'b1, 0);         // R5: wrap4 words
    send(32'h0000_1006, 2'd1, 7, 1'b1, 1'b1, 0);         // R5: wrap8 halfwords
    send(32'h0000_2007, 2'd0, 15, 1'b0, 1'b1, 0);        // R5: wrap16 bytes
    send(32'h0000_3000, 2'd2, 15, 1'b1, 1'b0, 0);        // R4/R11: incr16
    send(32'h0000_040C, 2'd2, 5, 1'b0, 1'b1, 0);         // R5: odd length wraps not
    send(32'h0000_0500, 2'd1, 0, 1'b0, 1'b0, 0);         // R9: back-to-back singles
    send(32'h0000_0502, 2'd1, 0, 1'b1, 1'b0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_ready = 1'b1;
    req_valid = 1'b1;
    req_addr = '0; req_size = '0; req_len = '0; req_wrap = 1'b0; req_write = 1'b0;
    src_wdata = '0; bus_rdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk(bus_trans == 2'b00, "R1", "reset trans", 64'(bus_trans), 64'(0));
    chk(req_ready == 1'b0, "R1", "reset req_ready", 64'(req_ready), 64'(0));
    chk(src_pop == 1'b0 && rd_valid == 1'b0, "R1", "reset strobes", 64'({src_pop, rd_valid}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    stall_pct = 0;
    directed_set();
    stall_pct = 45;
    directed_set();
    for (int i = 0; i < 160; i++) begin
      logic [1:0] sz;
      int len;
      logic wrap;
      sz = 2'($urandom_range(2));
      wrap = $urandom_range(1);
      if (wrap && $urandom_range(3) != 0) len = (4 << $urandom_range(2)) - 1;
      else len = $urandom_range(15);
      stall_pct = $urandom_range(50);
      send(($urandom & 32'h0000_FFFF) & ~((32'd1 << sz) - 32'd1), sz, len,
           1'($urandom_range(1)), wrap, (i % 4 == 0) ? 0 : $urandom_range(2));
    end
    stall_pct = 0;
    for (int j = 0; j < 40 && exq.size() != 0; j++) step();
    repeat (3) step();
    chk(beats_seen == beats_exp && exq.size() == 0, "R11", "beat total",
        64'(beats_seen), 64'(beats_exp));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule